// File: doc/BRIEF.md
# SPI Register-Access Slave

This block connects an external SPI master to an on-chip register file. Each frame opens with a command byte. The byte names one of 64 registers and says whether the master wants to read it or write it. On a read, the contents of the register follow the command inside the same frame. The number of data bits is set by the width the register file reports for that address. On a write, the master sends 16 new data bits. While those bits arrive, the block returns the register's current value on MISO, so every write also reads back the previous contents.

The serial pins are sampled by the block's own system clock through synchronizers, and the block detects the SCLK edges internally. The register file is reached through a parallel port in that same clock domain. The block presents an address, and the register file answers in the same cycle with the value, a width code and an "implemented" flag. Writes leave the block as a one-cycle strobe carrying the address and the 16-bit data. A write frame that is cut short by raising chip select never reaches the register file.

Top module: `spi_regif`

## Requirements
- R1: The command byte is sent MSB first. Its bits 7..2 are the register address, with address bit 5 first. Bit 0 selects the direction: 1 for a read, 0 for a write. The address appears on `reg_addr` during the command and for the rest of the frame.
- R2: Timing follows SPI mode 1. SCLK idles low. MOSI is sampled on the falling SCLK edge and MISO changes after the rising edge, MSB first. Each SCLK level must last at least SYNC_STAGES+3 `clk` periods.
- R3: On a read, the data starts at the rising edge that follows the command byte, with no gap. Its length comes from `reg_rwidth`: 2'b00 gives 16 bits, 2'b01 gives 24 bits and 2'b10 gives 40 bits. The value is taken from the low bits of `reg_rdata`.
- R4: MISO is 0 during the command byte. It is also 0 on any clock after the register's data bits have all been sent.
- R5: A write frame has 8 command bits and then 16 data bits. The register's current value goes out on MISO while the new value comes in.
- R6: A write reaches the register file as a single-cycle `reg_wr_en` pulse, with `reg_wdata` and `reg_addr` valid in that cycle. The pulse comes only after the 16th data bit has been sampled.
- R7: Raising `cs_n` ends the frame at once. It clears the bit count, and a write that is still incomplete is discarded. The next frame starts again from its command byte.
- R8: While `cs_n` is high, `miso_oe` is 0 and `miso` is 0. While `cs_n` is low, `miso_oe` is 1.
- R9: If bit 1 of the command byte is 1, the frame is invalid. A write in that frame produces no pulse, and a read returns zeros.
- R10: If the addressed register is not implemented (`reg_hit` low, or width code 2'b11), a write produces no pulse and a read returns zeros.
- R11: SCLK cycles after the 24th bit of a write frame are ignored. There is exactly one write, and it carries the first 16 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_addr | output | 6 | Register address presented to the register file |
| reg_rdata | input | 40 | Contents of the addressed register, right-aligned |
| reg_rwidth | input | 2 | Width code of the addressed register |
| reg_hit | input | 1 | The addressed register exists |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Data to be written |

## Verification
The bench builds the block with its default parameters: widths of 16, 24 and 40 bits, a 16-bit write, a 6-bit address and a two-stage synchronizer. SCLK runs with each level held for eight system clocks. The bench's register file reports all four width codes, including the reserved one, at addresses whose bit patterns expose any error in address bit order. It also leaves part of the address space unimplemented. One frame keeps clocking past the end of a write, which drives the bit counter toward saturation. Another frame is cut off in the middle of its data.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    typedef enum logic [1:0] {
        WID_SHORT = 2'd0,
        WID_MID   = 2'd1,
        WID_LONG  = 2'd2,
        WID_RSVD  = 2'd3
    } wid_code_e;

endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
    parameter int              STAGES  = 2,
    parameter int              N       = 3,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    typedef logic [STAGES-1:0][N-1:0] pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_regif_frame.sv
module spi_regif_frame
    import spi_regif_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 6,
    parameter int WR_W   = 16,
    parameter int MAX_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              reg_hit_i,
    input  logic [1:0]        rwidth_i,
    output logic              rise_o,
    output logic              load_o,
    output logic              load_ok_o,
    output logic              cmd_phase_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              wr_en_o,
    output logic [WR_W-1:0]   wdata_o
);
    localparam int                CNT_W    = $clog2(CMD_W + MAX_W + 2);
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
    localparam logic [CNT_W-1:0]  CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0]  CMD_LEN  = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0]  WR_LAST  = CNT_W'(CMD_W + WR_W - 1);
    localparam logic [CNT_W-1:0]  WR_END   = CNT_W'(CMD_W + WR_W);

    typedef struct packed {
        logic                  sclk_prev;
        logic [CNT_W-1:0]      cnt;
        logic [CMD_W-2:0]      cmd_sh;
        logic [ADDR_W-1:0]     addr;
        logic                  ok;
        logic                  is_rd;
        logic [WR_W-2:0]       wsh;
        logic                  wr_en;
        logic [WR_W-1:0]       wdata;
    } frame_t;

    frame_t st_d, st_q;

    logic             rise, fall, cmd_phase, last_cmd, impl, cmd_ok;
    logic [CMD_W-1:0] cmd_byte;

    always_comb begin
        rise      = active_i &  sclk_i & ~st_q.sclk_prev;
        fall      = active_i & ~sclk_i &  st_q.sclk_prev;
        cmd_phase = st_q.cnt < CMD_LEN;
        last_cmd  = fall && (st_q.cnt == CMD_LAST);
        cmd_byte  = {st_q.cmd_sh, mosi_i};
        impl      = reg_hit_i && (wid_code_e'(rwidth_i) != WID_RSVD);
        cmd_ok    = impl && !cmd_byte[1];

        st_d           = st_q;
        st_d.sclk_prev = sclk_i;
        st_d.wr_en     = 1'b0;

        if (!active_i) begin
            st_d.cnt    = '0;
            st_d.cmd_sh = '0;
            st_d.wsh    = '0;
            st_d.ok     = 1'b0;
            st_d.is_rd  = 1'b0;
        end else if (fall) begin
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (cmd_phase) begin
                st_d.cmd_sh = cmd_byte[CMD_W-2:0];
                if (last_cmd) begin
                    st_d.addr  = cmd_byte[CMD_W-1 -: ADDR_W];
                    st_d.ok    = cmd_ok;
                    st_d.is_rd = cmd_byte[0];
                end
            end else if (st_q.cnt < WR_END) begin
                st_d.wsh = {st_q.wsh[WR_W-3:0], mosi_i};
                if (st_q.cnt == WR_LAST && st_q.ok && !st_q.is_rd) begin
                    st_d.wr_en = 1'b1;
                    st_d.wdata = {st_q.wsh, mosi_i};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o      = rise;
    assign load_o      = last_cmd;
    assign load_ok_o   = cmd_ok;
    assign cmd_phase_o = cmd_phase;
    assign reg_addr_o  = cmd_phase ? st_q.cmd_sh[CMD_W-2 -: ADDR_W] : st_q.addr;
    assign wr_en_o     = st_q.wr_en;
    assign wdata_o     = st_q.wdata;

    // R6
    wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |=> !st_q.wr_en);

    // R6
    wr_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |-> (st_q.cnt == WR_END));

    // R7
    wr_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |-> active_i);

    // R9
    wr_needs_valid_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_en |-> (st_q.ok && !st_q.is_rd));

endmodule

// File: rtl/spi_regif_tx.sv
module spi_regif_tx
    import spi_regif_pkg::*;
#(
    parameter int W_SHORT = 16,
    parameter int W_MID   = 24,
    parameter int W_LONG  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              rise_i,
    input  logic              cmd_phase_i,
    input  logic              load_i,
    input  logic              load_ok_i,
    input  logic [W_LONG-1:0] rdata_i,
    input  logic [1:0]        rwidth_i,
    output logic              miso_o,
    output logic              miso_oe_o
);
    typedef struct packed {
        logic [W_LONG-1:0] out;
        logic              miso;
        logic              oe;
    } tx_t;

    tx_t st_d, st_q;

    logic [W_LONG-1:0] aligned;

    always_comb begin
        aligned = '0;
        case (wid_code_e'(rwidth_i))
            WID_SHORT: aligned[W_LONG-1 -: W_SHORT] = rdata_i[W_SHORT-1:0];
            WID_MID:   aligned[W_LONG-1 -: W_MID]   = rdata_i[W_MID-1:0];
            WID_LONG:  aligned                      = rdata_i;
            default:   aligned                      = '0;
        endcase

        st_d    = st_q;
        st_d.oe = active_i;
        if (!active_i) begin
            st_d.out  = '0;
            st_d.miso = 1'b0;
        end else if (load_i) begin
            st_d.out = load_ok_i ? aligned : '0;
        end else if (rise_i) begin
            st_d.miso = st_q.out[W_LONG-1];
            st_d.out  = {st_q.out[W_LONG-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso_o    = st_q.miso;
    assign miso_oe_o = st_q.oe;

    // R4
    cmd_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && cmd_phase_i) |=> !st_q.miso);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !st_q.oe) |-> !st_q.miso);

endmodule

// File: rtl/spi_regif.sv
module spi_regif #(
    parameter int W_SHORT     = 16,
    parameter int W_MID       = 24,
    parameter int W_LONG      = 40,
    parameter int ADDR_W      = 6,
    parameter int CMD_W       = 8,
    parameter int WR_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    input  logic [W_LONG-1:0] reg_rdata,
    input  logic [1:0]        reg_rwidth,
    input  logic              reg_hit,
    output logic              reg_wr_en,
    output logic [WR_W-1:0]   reg_wdata
);
    logic [2:0] pins_s;
    logic       active, rise, load, load_ok, cmd_phase;

    spi_regif_sync #(
        .STAGES (SYNC_STAGES),
        .N      (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, sclk, mosi}),
        .q    (pins_s)
    );

    assign active = ~pins_s[2];

    spi_regif_frame #(
        .CMD_W (CMD_W),
        .ADDR_W(ADDR_W),
        .WR_W  (WR_W),
        .MAX_W (W_LONG)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .sclk_i     (pins_s[1]),
        .mosi_i     (pins_s[0]),
        .reg_hit_i  (reg_hit),
        .rwidth_i   (reg_rwidth),
        .rise_o     (rise),
        .load_o     (load),
        .load_ok_o  (load_ok),
        .cmd_phase_o(cmd_phase),
        .reg_addr_o (reg_addr),
        .wr_en_o    (reg_wr_en),
        .wdata_o    (reg_wdata)
    );

    spi_regif_tx #(
        .W_SHORT(W_SHORT),
        .W_MID  (W_MID),
        .W_LONG (W_LONG)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .rise_i     (rise),
        .cmd_phase_i(cmd_phase),
        .load_i     (load),
        .load_ok_i  (load_ok),
        .rdata_i    (reg_rdata),
        .rwidth_i   (reg_rwidth),
        .miso_o     (miso),
        .miso_oe_o  (miso_oe)
    );

    // R8
    oe_tracks_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |=> miso_oe);

endmodule

// File: tb/tb_spi_regif.sv
module tb_spi_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso, miso_oe, reg_wr_en, reg_hit;
    logic [5:0]  reg_addr;
    logic [39:0] reg_rdata;
    logic [1:0]  reg_rwidth;
    logic [15:0] reg_wdata;

    logic [39:0] mem [64];
    int          wr_cnt;
    logic [5:0]  last_wa;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    localparam int HALF = 160;

    always #10 clk = ~clk;

    spi_regif dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr),
        .reg_rdata(reg_rdata), .reg_rwidth(reg_rwidth), .reg_hit(reg_hit),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata)
    );

    // Register file model: implemented below 40; width by low address bits; 39 reserved code
    function automatic logic [1:0] wcode(input logic [5:0] a);
        if (a == 6'd39)        return 2'b11;
        else if (a[1:0] == 2'd2) return 2'b01;
        else if (a[1:0] == 2'd3) return 2'b10;
        else                   return 2'b00;
    endfunction

    function automatic int wbits(input logic [5:0] a);
        case (wcode(a))
            2'b01:   return 24;
            2'b10:   return 40;
            default: return 16;
        endcase
    endfunction

    assign reg_hit    = reg_addr < 6'd40;
    assign reg_rwidth = wcode(reg_addr);
    assign reg_rdata  = mem[reg_addr];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < 64; a++)
                mem[a] <= {8'(a) ^ 8'h5A, 32'hC3A51E96 ^ (32'(a) * 32'h01030507)};
            wr_cnt  <= 0;
            last_wa <= '0;
        end else if (reg_wr_en) begin
            mem[reg_addr][15:0] <= reg_wdata;
            wr_cnt  <= wr_cnt + 1;
            last_wa <= reg_addr;
        end
    end

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] expect_rd(input logic [5:0] a);
        return mem[a] & ((40'd1 << wbits(a)) - 40'd1);
    endfunction

    task automatic xfer(input logic [7:0] cmd, input logic [39:0] tx, input int nd,
                        output logic [7:0] rx_cmd, output logic [39:0] rx_d,
                        output logic oe_seen);
        logic [47:0] acc = '0;
        cs_n = 1'b0;
        #(HALF);
        for (int i = 0; i < 8 + nd; i++) begin
            sclk = 1'b1;
            mosi = (i < 8) ? cmd[7-i] : tx[nd-1-(i-8)];
            #(HALF);
            acc = {acc[46:0], miso};
            if (i == 0) oe_seen = miso_oe;
            sclk = 1'b0;
            #(HALF);
        end
        cs_n = 1'b1;
        mosi = 1'b0;
        #(2*HALF);
        rx_d   = 40'(acc & ((48'd1 << nd) - 48'd1));
        rx_cmd = 8'(acc >> nd);
    endtask

    task automatic t_reset();
        check("R8 reset miso_oe", 48'(miso_oe), 48'd0);
        check("R8 reset miso", 48'(miso), 48'd0);
        check("R6 reset no write", 48'(wr_cnt), 48'd0);
    endtask

    task automatic t_reads();
        logic [7:0] rc; logic [39:0] rd; logic oe;
        logic [5:0] a;
        a = 6'h21;
        xfer({a, 2'b01}, '0, 16, rc, rd, oe);
        check("R4 read cmd phase zero", 48'(rc), 48'd0);
        check("R1 R3 read 16-bit", 48'(rd), 48'(expect_rd(a)));
        check("R8 oe during frame", 48'(oe), 48'd1);
        check("R8 oe after frame", 48'(miso_oe), 48'd0);
        a = 6'h1A;
        xfer({a, 2'b01}, '0, 24, rc, rd, oe);
        check("R3 read 24-bit", 48'(rd), 48'(expect_rd(a)));
        a = 6'h27 - 6'd4;
        xfer({a, 2'b01}, '0, 40, rc, rd, oe);
        check("R3 read 40-bit", 48'(rd), 48'(expect_rd(a)));
        a = 6'h10;
        xfer({a, 2'b01}, '0, 40, rc, rd, oe);
        check("R4 zeros after data", 48'(rd), 48'({expect_rd(a)[15:0], 24'd0}));
    endtask

    task automatic t_write();
        logic [7:0] rc; logic [39:0] rd; logic oe;
        logic [39:0] old; int c0;
        old = expect_rd(6'h25);
        c0  = wr_cnt;
        xfer({6'h25, 2'b00}, 40'h5A3C, 16, rc, rd, oe);
        check("R5 old value out", 48'(rd), 48'(old));
        check("R6 one write pulse", 48'(wr_cnt - c0), 48'd1);
        check("R1 write address", 48'(last_wa), 48'h25);
        xfer({6'h25, 2'b01}, '0, 16, rc, rd, oe);
        check("R5 new value stored", 48'(rd), 48'h5A3C);
    endtask

    task automatic t_bad_cmd();
        logic [7:0] rc; logic [39:0] rd; logic oe;
        int c0; logic [39:0] keep;
        keep = expect_rd(6'h21);
        c0 = wr_cnt;
        xfer({6'h21, 2'b10}, 40'hFFFF, 16, rc, rd, oe);
        check("R9 bad write no pulse", 48'(wr_cnt - c0), 48'd0);
        check("R9 bad write zeros out", 48'(rd), 48'd0);
        xfer({6'h21, 2'b11}, '0, 16, rc, rd, oe);
        check("R9 bad read zeros", 48'(rd), 48'd0);
        xfer({6'h21, 2'b01}, '0, 16, rc, rd, oe);
        check("R9 register unchanged", 48'(rd), 48'(keep));
    endtask

    task automatic t_unimpl();
        logic [7:0] rc; logic [39:0] rd; logic oe;
        int c0;
        c0 = wr_cnt;
        xfer({6'h30, 2'b01}, '0, 16, rc, rd, oe);
        check("R10 unimplemented read zeros", 48'(rd), 48'd0);
        xfer({6'h30, 2'b00}, 40'h1234, 16, rc, rd, oe);
        check("R10 unimplemented write no pulse", 48'(wr_cnt - c0), 48'd0);
        xfer({6'd39, 2'b01}, '0, 40, rc, rd, oe);
        check("R10 reserved width read zeros", 48'(rd), 48'd0);
        xfer({6'd39, 2'b00}, 40'h1234, 16, rc, rd, oe);
        check("R10 reserved width write no pulse", 48'(wr_cnt - c0), 48'd0);
    endtask

    task automatic t_abort();
        logic [7:0] rc; logic [39:0] rd; logic oe;
        int c0; logic [39:0] keep;
        keep = expect_rd(6'h21);
        c0 = wr_cnt;
        xfer({6'h21, 2'b00}, 40'h3FF, 10, rc, rd, oe);
        check("R7 aborted write no pulse", 48'(wr_cnt - c0), 48'd0);
        xfer({6'h21, 2'b01}, '0, 16, rc, rd, oe);
        check("R7 fresh frame after abort", 48'(rd), 48'(keep));
    endtask

    task automatic t_overrun();
        logic [7:0] rc; logic [39:0] rd; logic oe;
        int c0;
        c0 = wr_cnt;
        xfer({6'h20, 2'b00}, 40'hBEEF_C3, 24, rc, rd, oe);
        check("R11 single pulse on overrun", 48'(wr_cnt - c0), 48'd1);
        xfer({6'h20, 2'b01}, '0, 16, rc, rd, oe);
        check("R11 first 16 bits kept", 48'(rd), 48'hBEEF);
    endtask

    initial begin
        #103;
        t_reset();
        rst_n = 1'b1;
        #200;
        // R2: every frame below uses mode-1 timing, MSB first
        t_reads();
        t_write();
        t_bad_cmd();
        t_unimpl();
        t_abort();
        t_overrun();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule